// File: doc/BRIEF.md
# Amplifier Power Mode Controller

This block decides which power state an audio amplifier sits in and drives the enables for its supplies, its output stage and its signal processor. A host reaches it through a small register write port (address, data, strobe). Two selector registers pick the active register bank: one holds a book number and one holds a page number. A 2-bit mode field at a fixed address then asks for one of four operating states. An active-low power-down pin overrides everything. While the pin is low, both regulators are off and every register returns to its default.

The states are shutdown (SHDN), deep sleep (DEEP), sleep (SLEEP), output high-impedance (HIZ) and play (PLAY). Transitions follow these rules:
- SHDN→DEEP happens on the first edge after the pin is released.
- From SLEEP or HIZ, a single play request moves straight to PLAY.
- Any non-play request moves to the requested state.
- A deep-sleep request re-arms a guard. Once armed, the guard refuses play until the host has written the mode sequence hi-Z, deep, hi-Z, play.
- A refused play request sends the block back to DEEP and raises a sticky error flag.

In PLAY, the output driver is enabled only after the analog-ready input has been high for a set number of cycles.

Top module: `amp_pwr_mode_ctrl`

## Requirements
- R1: While `pdn_n` is low, `state` reads 0 (SHDN). `core_ldo_en`, `ana_ldo_en`, `drv_en` and `dsp_run` are 0 and `out_hiz` is 1. The book and page registers return to 0, the exit guard re-arms and `seq_err` clears.
- R2: On the first rising clock edge after `pdn_n` goes high, `state` becomes 1 (DEEP). A mode write made in that cycle has no effect.
- R3: Address 0x7F holds the book register and address 0x00 holds the page register. Address 0x68 bits [1:0] is the mode field. A mode write takes effect only while book and page are both 0; otherwise it changes neither `state` nor `seq_err`.
- R4: Mode 00 requests DEEP (state 1), 01 requests SLEEP (state 2), 10 requests HIZ (state 3) and 11 requests PLAY (state 4). The state changes on the clock edge that samples the write.
- R5: In DEEP, `core_ldo_en`=1 and `ana_ldo_en`=0. In SLEEP and HIZ, both enables are 1. In every state except SHDN, `dsp_run` is 1. Outside PLAY, `drv_en` is 0 and `out_hiz` is 1.
- R6: When the guard is not armed, a single write of 11 from SLEEP or HIZ moves the block to PLAY.
- R7: When the guard is armed, PLAY is reached only after the consecutive accepted mode writes 10, 00, 10, 11. Visiting SLEEP or breaking the order restarts the count; an out-of-order 10 counts as a new first step.
- R8: A write of 11 while the guard is armed and the sequence is incomplete moves the block to DEEP, sets `seq_err` and restarts the sequence.
- R9: `seq_err` holds until the next accepted mode write that is not refused, which clears it. Book or page writes do not clear it.
- R10: In PLAY, `drv_en` goes to 1 once `ana_ready` has been sampled high on SETTLE_CYC consecutive edges while the analog regulator is on. A low sample clears the count, and `drv_en` falls on that edge. `out_hiz` is always the inverse of `drv_en`.
- R11: A write of 00 while the guard is not armed moves the block to DEEP and re-arms the guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pdn_n | input | 1 | Active-low power-down; asynchronous wipe of all state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| ana_ready | input | 1 | Analog supply ready indication |
| core_ldo_en | output | 1 | Core regulator enable |
| ana_ldo_en | output | 1 | Analog / gate-driver regulator enable |
| drv_en | output | 1 | Output driver enable |
| out_hiz | output | 1 | Output tri-state control |
| dsp_run | output | 1 | Signal processor run flag |
| state | output | 3 | Current state code (0 SHDN, 1 DEEP, 2 SLEEP, 3 HIZ, 4 PLAY) |
| seq_err | output | 1 | Sticky deep-sleep exit sequence error |

## Verification
The assertions assume that `wr_en`, `wr_addr`, `wr_data` and `ana_ready` change only between clock edges. They also assume that `pdn_n` is released away from an active edge, so a write is sampled exactly once and the settle count sees a clean level each cycle. The stimulus keeps within this: every input changes on the falling edge, each write strobe lasts one cycle, and `pdn_n` is both pulled low and released at a falling edge.

// File: rtl/amp_pwr_pkg.sv
package amp_pwr_pkg;

    typedef enum logic [2:0] {
        ST_SHDN  = 3'd0,
        ST_DEEP  = 3'd1,
        ST_SLEEP = 3'd2,
        ST_HIZ   = 3'd3,
        ST_PLAY  = 3'd4
    } pwr_state_e;

    localparam logic [1:0] MODE_DEEP  = 2'b00;
    localparam logic [1:0] MODE_SLEEP = 2'b01;
    localparam logic [1:0] MODE_HIZ   = 2'b10;
    localparam logic [1:0] MODE_PLAY  = 2'b11;

    localparam logic [7:0] ADDR_PAGE = 8'h00;
    localparam logic [7:0] ADDR_BOOK = 8'h7F;
    localparam logic [7:0] ADDR_MODE = 8'h68;

    function automatic pwr_state_e mode_to_state(input logic [1:0] m);
        unique case (m)
            MODE_DEEP:  return ST_DEEP;
            MODE_SLEEP: return ST_SLEEP;
            MODE_HIZ:   return ST_HIZ;
            default:    return ST_PLAY;
        endcase
    endfunction

endpackage

// File: rtl/amp_cfg_regs.sv
module amp_cfg_regs
    import amp_pwr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              mode_wr,
    output logic [1:0]        mode_val
);
    localparam logic [ADDR_W-1:0] A_PAGE = ADDR_W'(ADDR_PAGE);
    localparam logic [ADDR_W-1:0] A_BOOK = ADDR_W'(ADDR_BOOK);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);

    logic [DATA_W-1:0] book_q;
    logic [DATA_W-1:0] page_q;
    logic              bank_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            book_q <= '0;
            page_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_BOOK) book_q <= wr_data;
            if (wr_addr == A_PAGE) page_q <= wr_data;
        end
    end

    assign bank_zero = (book_q == '0) && (page_q == '0);
    assign mode_wr   = wr_en && (wr_addr == A_MODE) && bank_zero;
    assign mode_val  = wr_data[1:0];

    // R3: a mode write is accepted only with book and page at zero
    a_r3_bank_gate: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |-> (book_q == '0 && page_q == '0));

endmodule

// File: rtl/amp_exit_guard.sv
module amp_exit_guard
    import amp_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [1:0] mode_val,
    output logic       refuse,
    output logic       seq_err
);
    localparam int STEPS = 3;
    localparam int SW    = $clog2(STEPS + 1);

    logic          armed_q;
    logic [SW-1:0] stage_q;
    logic [1:0]    expect_mode;

    always_comb begin
        unique case (stage_q)
            SW'(0):  expect_mode = MODE_HIZ;
            SW'(1):  expect_mode = MODE_DEEP;
            SW'(2):  expect_mode = MODE_HIZ;
            default: expect_mode = MODE_PLAY;
        endcase
    end

    assign refuse = mode_wr && armed_q && (mode_val == MODE_PLAY) && (stage_q != SW'(STEPS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            stage_q <= '0;
            seq_err <= 1'b0;
        end else if (mode_wr) begin
            seq_err <= refuse;
            if (armed_q) begin
                if (mode_val == MODE_PLAY) begin
                    stage_q <= '0;
                    armed_q <= refuse;
                end else if (mode_val == expect_mode) begin
                    stage_q <= stage_q + SW'(1);
                end else begin
                    stage_q <= (mode_val == MODE_HIZ) ? SW'(1) : SW'(0);
                end
            end else if (mode_val == MODE_DEEP) begin
                armed_q <= 1'b1;
                stage_q <= '0;
            end
        end
    end

    // R8: a refused play request raises the error flag
    a_r8_refuse_flags: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |=> seq_err);
    // R9: an accepted, non-refused mode write clears the flag
    a_r9_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !refuse) |=> !seq_err);

endmodule

// File: rtl/amp_settle_timer.sv
module amp_settle_timer #(
    parameter int SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ana_on,
    input  logic ana_ready,
    output logic settled
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (!(ana_on && ana_ready)) cnt_q <= '0;
        else if (cnt_q != LIMIT)       cnt_q <= cnt_q + CW'(1);
    end

    assign settled = (cnt_q == LIMIT);

    // R10: settling needs the ready input seen high on the previous edge
    a_r10_ready_seen: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> $past(ana_ready));

endmodule

// File: rtl/amp_pwr_mode_ctrl.sv
module amp_pwr_mode_ctrl
    import amp_pwr_pkg::*;
#(
    parameter int SETTLE_CYC = 4
) (
    input  logic       clk,
    input  logic       pdn_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       ana_ready,
    output logic       core_ldo_en,
    output logic       ana_ldo_en,
    output logic       drv_en,
    output logic       out_hiz,
    output logic       dsp_run,
    output logic [2:0] state,
    output logic       seq_err
);
    pwr_state_e state_q, state_d;
    logic       mode_wr, mode_go, refuse, settled;
    logic [1:0] mode_val;

    amp_cfg_regs #(.ADDR_W(8), .DATA_W(8)) u_regs (
        .clk(clk), .rst_n(pdn_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_wr(mode_wr), .mode_val(mode_val)
    );

    assign mode_go = mode_wr && (state_q != ST_SHDN);

    amp_exit_guard u_guard (
        .clk(clk), .rst_n(pdn_n), .mode_wr(mode_go), .mode_val(mode_val),
        .refuse(refuse), .seq_err(seq_err)
    );

    amp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(pdn_n), .ana_on(ana_ldo_en),
        .ana_ready(ana_ready), .settled(settled)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHDN: state_d = ST_DEEP;
            ST_DEEP, ST_SLEEP, ST_HIZ, ST_PLAY: begin
                if (mode_go) state_d = refuse ? ST_DEEP : mode_to_state(mode_val);
            end
            default: state_d = ST_SHDN;
        endcase
    end

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) state_q <= ST_SHDN;
        else        state_q <= state_d;
    end

    always_comb begin
        core_ldo_en = 1'b1;
        ana_ldo_en  = 1'b1;
        dsp_run     = 1'b1;
        drv_en      = 1'b0;
        unique case (state_q)
            ST_SHDN: begin
                core_ldo_en = 1'b0;
                ana_ldo_en  = 1'b0;
                dsp_run     = 1'b0;
            end
            ST_DEEP:  ana_ldo_en = 1'b0;
            ST_SLEEP: ;
            ST_HIZ:   ;
            ST_PLAY:  drv_en = settled;
            default: begin
                core_ldo_en = 1'b0;
                ana_ldo_en  = 1'b0;
                dsp_run     = 1'b0;
            end
        endcase
        out_hiz = !drv_en;
    end

    assign state = state_q;

    // R2: shutdown always gives way to deep sleep on the next edge
    a_r2_wake_deep: assert property (@(posedge clk) disable iff (!pdn_n)
        (state_q == ST_SHDN) |=> (state_q == ST_DEEP));
    // R8: a refused play request lands in deep sleep
    a_r8_refuse_deep: assert property (@(posedge clk) disable iff (!pdn_n)
        refuse |=> (state_q == ST_DEEP));
    // R7: play is entered from hi-Z or sleep only, never straight from deep sleep
    a_r7_no_deep_to_play: assert property (@(posedge clk) disable iff (!pdn_n)
        (state_q == ST_DEEP) |=> (state_q != ST_PLAY));
    // R10: the driver is enabled only in play with the analog regulator on
    a_r10_drv_play_only: assert property (@(posedge clk) disable iff (!pdn_n)
        drv_en |-> (state_q == ST_PLAY && ana_ldo_en && !out_hiz));

endmodule

// File: tb/tb_amp_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_amp_pwr_mode_ctrl;

    logic       clk = 1'b0;
    logic       pdn_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ana_ready = 1'b0;
    logic       core_ldo_en, ana_ldo_en, drv_en, out_hiz, dsp_run, seq_err;
    logic [2:0] state;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    amp_pwr_mode_ctrl #(.SETTLE_CYC(4)) dut (
        .clk(clk), .pdn_n(pdn_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ana_ready(ana_ready), .core_ldo_en(core_ldo_en),
        .ana_ldo_en(ana_ldo_en), .drv_en(drv_en), .out_hiz(out_hiz),
        .dsp_run(dsp_run), .state(state), .seq_err(seq_err)
    );

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] d;
        logic [2:0] st;
        logic       err;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{8'h68, 8'h03, 3'd1, 1'b1},  // R8 direct play from deep refused
        '{8'h68, 8'h02, 3'd3, 1'b0},  // R9 clears, step 1
        '{8'h68, 8'h03, 3'd1, 1'b1},  // R8 out of order
        '{8'h68, 8'h02, 3'd3, 1'b0},  // R7 step 1
        '{8'h68, 8'h00, 3'd1, 1'b0},  // R7 step 2
        '{8'h68, 8'h02, 3'd3, 1'b0},  // R7 step 3
        '{8'h68, 8'h03, 3'd4, 1'b0},  // R7 play reached
        '{8'h68, 8'h01, 3'd2, 1'b0},  // R4 sleep
        '{8'h68, 8'h03, 3'd4, 1'b0},  // R6 sleep to play
        '{8'h68, 8'h02, 3'd3, 1'b0},  // R4 hi-Z
        '{8'h68, 8'h03, 3'd4, 1'b0},  // R6 hi-Z to play
        '{8'h7F, 8'h01, 3'd4, 1'b0},  // R3 book to 1
        '{8'h68, 8'h00, 3'd4, 1'b0},  // R3 ignored, book nonzero
        '{8'h7F, 8'h00, 3'd4, 1'b0},  // R3 book back to 0
        '{8'h00, 8'h05, 3'd4, 1'b0},  // R3 page to 5
        '{8'h68, 8'h00, 3'd4, 1'b0},  // R3 ignored, page nonzero
        '{8'h00, 8'h00, 3'd4, 1'b0},  // R3 page back to 0
        '{8'h68, 8'h00, 3'd1, 1'b0},  // R11 re-arm
        '{8'h68, 8'h01, 3'd2, 1'b0},  // R7 sleep while armed
        '{8'h68, 8'h03, 3'd1, 1'b1},  // R8 still armed
        '{8'h68, 8'h02, 3'd3, 1'b0},  // R7 step 1
        '{8'h68, 8'h00, 3'd1, 1'b0},  // R7 step 2
        '{8'h68, 8'h02, 3'd3, 1'b0},  // R7 step 3
        '{8'h68, 8'h03, 3'd4, 1'b0},  // R7 play
        '{8'h68, 8'hFD, 3'd2, 1'b0},  // R4 only bits [1:0] used
        '{8'h68, 8'h03, 3'd4, 1'b0}   // R6 back to play
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_rails(input string req, input logic [2:0] st);
        check(req, core_ldo_en, st != 3'd0);
        check(req, ana_ldo_en, st >= 3'd2);
        check(req, dsp_run, st != 3'd0);
        if (st != 3'd4) begin
            check(req, drv_en, 1'b0);
            check(req, out_hiz, 1'b1);
        end
    endtask

    initial begin
        #3;
        // R1 reset state while power-down is held low
        check("R1 state", state, 3'd0);
        check_rails("R1 rails", 3'd0);
        check("R1 err", seq_err, 1'b0);

        // R2 first edge after release gives deep sleep; a write in that cycle is dropped
        @(negedge clk);
        pdn_n = 1'b1;
        wr_en = 1'b1; wr_addr = 8'h68; wr_data = 8'h02;
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 state", state, 3'd1);
        check_rails("R5 deep rails", 3'd1);

        ana_ready = 1'b1;
        for (int i = 0; i < NV; i++) begin
            write_reg(VECS[i].a, VECS[i].d);
            check($sformatf("R4 vec%0d state", i), state, VECS[i].st);
            check($sformatf("R9 vec%0d err", i), seq_err, VECS[i].err);
            check_rails($sformatf("R5 vec%0d rails", i), VECS[i].st);
        end

        // R10 driver waits for ready to settle
        ana_ready = 1'b0;
        write_reg(8'h68, 8'h00);
        write_reg(8'h68, 8'h02);
        write_reg(8'h68, 8'h00);
        write_reg(8'h68, 8'h02);
        write_reg(8'h68, 8'h03);
        check("R10 play entered", state, 3'd4);
        check("R10 drv off without ready", drv_en, 1'b0);
        repeat (2) @(negedge clk);
        check("R10 still off", drv_en, 1'b0);
        ana_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 three edges not enough", drv_en, 1'b0);
        @(negedge clk);
        check("R10 driver on", drv_en, 1'b1);
        check("R10 hiz low", out_hiz, 1'b0);
        ana_ready = 1'b0;
        @(negedge clk);
        check("R10 ready drop", drv_en, 1'b0);
        check("R10 hiz back", out_hiz, 1'b1);

        // R1 power-down wipes book and error flag
        write_reg(8'h68, 8'h00);
        write_reg(8'h68, 8'h03);
        check("R8 err before pdn", seq_err, 1'b1);
        write_reg(8'h7F, 8'h01);
        @(negedge clk);
        pdn_n = 1'b0;
        #1;
        check("R1 state in pdn", state, 3'd0);
        check("R1 err wiped", seq_err, 1'b0);
        check_rails("R1 rails in pdn", 3'd0);
        @(negedge clk);
        pdn_n = 1'b1;
        @(negedge clk);
        check("R2 deep after release", state, 3'd1);
        write_reg(8'h68, 8'h02);
        check("R1 book wiped", state, 3'd3);
        write_reg(8'h68, 8'h03);
        check("R7 guard re-armed by pdn", state, 3'd1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule